// File: doc/BRIEF.md
# Audio interrupt status aggregator

This block builds the single 32-bit interrupt status and control word of a multi-engine audio controller. It gathers the live request lines of the engines into summary bits. These are two legacy audio lines, a timer request gated by its own enable, the OR of the per-channel address-engine vectors of two voice banks, the OR of the per-channel envelope vector, a sample-timer request and a GPIO request formed from four bits. The word also holds sticky error flags: playback FIFO underrun, record overrun, mixer accumulator underflow and overflow, and sample-timer target reached.

Software reads the word through `rd_data_o`. A write (`wr_en_i` with `wr_data_i`) clears any sticky flag whose data bit is 1. The same write loads the playback half-rate mode bit and the two interrupt-enable bits. The bit positions are fixed, because driver software decodes them. Live bits follow their inputs in the same cycle. Sticky flags and control bits change on the clock edge after the event.

Top module: `audio_irq_status`

## Requirements
- R1: Bit 2 reads the first legacy audio request `sb_irq_i` and bit 3 reads the second, `mpu_irq_i`, in the same cycle.
- R2: Bit 17 is a read/write timer-interrupt enable that resets to 0. Bit 4 reads `tmr_irq_i` AND bit 17.
- R3: Bit 5 is 1 when any bit of `addr_int_a_i` or `addr_int_b_i` is 1. Bit 6 is 1 when any bit of `env_int_i` is 1.
- R4: Bit 8 (underrun) becomes 1 on the edge after a cycle where `pb_run_i`, `pb_fifo_empty_i` and `f48_tick_i` are all 1, and it stays 1 until it is cleared.
- R5: Bit 9 (overrun) becomes 1 on the edge after a cycle where `rec_run_i` and `rec_req_i` are 1 and `rec_data_rdy_i` is 0. It is sticky.
- R6: When `mix_valid_i` is 1, a signed `mix_acc_i` below -0x80000 sets bit 10 and a value above 0x7FFFF sets bit 11. The values -0x80000 and 0x7FFFF set neither bit. Both bits are sticky.
- R7: Bit 15 becomes 1 on the edge after `st_count_i` equals `st_target_i` and is sticky. Bit 23 is a read/write enable that resets to 0. Bit 7 reads bit 15 AND bit 23.
- R8: Bit 16 is a read/write playback mode bit that resets to 0 (full rate, 48 kHz). A 1 selects half rate (24 kHz). `pb_half_rate_o` carries its value.
- R9: Bit 24 reads (`gpio_bits_i[0]` AND `gpio_bits_i[2]`) OR (`gpio_bits_i[1]` AND `gpio_bits_i[3]`).
- R10: A write with data bit 1 clears sticky bits 8, 9, 10, 11 and 15 on the next edge, and a data bit 0 leaves them unchanged. If a set condition and the clearing write fall in the same cycle, the bit ends up 1.
- R11: Bits 0, 1, 12 to 14, 18 to 22 and 25 to 31 always read 0, whatever is written. After reset, with all inputs low, the word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sb_irq_i | input | 1 | First legacy audio request |
| mpu_irq_i | input | 1 | Second legacy audio request |
| tmr_irq_i | input | 1 | Raw timer request |
| addr_int_a_i | input | NCH | Address-engine per-channel requests, bank A |
| addr_int_b_i | input | NCH | Address-engine per-channel requests, bank B |
| env_int_i | input | NCH | Envelope-engine per-channel requests |
| pb_run_i | input | 1 | Playback running |
| pb_fifo_empty_i | input | 1 | Playback FIFO empty |
| f48_tick_i | input | 1 | 48 kHz sample strobe |
| rec_run_i | input | 1 | Recording running |
| rec_req_i | input | 1 | Record request pending |
| rec_data_rdy_i | input | 1 | Record data ready |
| mix_valid_i | input | 1 | Mixer accumulator result valid |
| mix_acc_i | input | ACC_W | Signed mixer accumulator result |
| st_count_i | input | ST_W | Sample timer count |
| st_target_i | input | ST_W | Sample timer target |
| gpio_bits_i | input | 4 | GPIO status and enable bits |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data |
| pb_half_rate_o | output | 1 | Playback half-rate mode |

## Verification
Two events can land on the same sticky flag in one cycle: its set condition, and a software write that clears it. The bench forces this case in directed cycles. For example, it presents an out-of-range accumulator together with a write that has bit 11 set. It then expects the flag to read 1 after the edge. A later cycle carries the write alone and must read 0. Random cycles also raise set conditions and clearing writes together often enough to cover this pairing on every flag. The bench model gives the set priority, and each cycle's read word is compared against that model.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;
   localparam int DATA_W = 32;

   localparam int B_SB   = 2;
   localparam int B_MPU  = 3;
   localparam int B_TMR  = 4;
   localparam int B_ADDR = 5;
   localparam int B_ENV  = 6;
   localparam int B_ST   = 7;
   localparam int B_UND  = 8;
   localparam int B_OVR  = 9;
   localparam int B_MUF  = 10;
   localparam int B_MOF  = 11;
   localparam int B_TGT  = 15;
   localparam int B_HALF = 16;
   localparam int B_TIE  = 17;
   localparam int B_SIE  = 23;
   localparam int B_GPIO = 24;

   localparam int NFLAG  = 5;
   localparam int FI_UND = 0;
   localparam int FI_OVR = 1;
   localparam int FI_MUF = 2;
   localparam int FI_MOF = 3;
   localparam int FI_TGT = 4;

   localparam logic [DATA_W-1:0] DEF_MASK = 32'h0183_8FFC;

   function automatic int flag_bit(input int idx);
      case (idx)
         FI_UND:  return B_UND;
         FI_OVR:  return B_OVR;
         FI_MUF:  return B_MUF;
         FI_MOF:  return B_MOF;
         default: return B_TGT;
      endcase
   endfunction
endpackage

// File: rtl/irq_vec_reduce.sv
module irq_vec_reduce #(
   parameter int NCH  = 32,
   parameter int NVEC = 1
) (
   input  logic [NVEC*NCH-1:0] vec_i,
   output logic                any_o
);
   if (NCH < 1 || NVEC < 1) begin : g_bad
      $error("irq_vec_reduce: NCH and NVEC must be at least 1");
   end

   if (NVEC == 1) begin : g_single
      assign any_o = |vec_i;
   end else begin : g_multi
      logic [NVEC-1:0] part;
      for (genvar v = 0; v < NVEC; v++) begin : g_part
         assign part[v] = |vec_i[v*NCH +: NCH];
      end
      assign any_o = |part;
   end
endmodule

// File: rtl/mix_sat_detect.sv
module mix_sat_detect #(
   parameter int ACC_W = 24,
   parameter int SAT_W = 20
) (
   input  logic             valid_i,
   input  logic [ACC_W-1:0] acc_i,
   output logic             under_o,
   output logic             over_o
);
   if (SAT_W < 2 || SAT_W >= ACC_W || ACC_W > 62) begin : g_bad
      $error("mix_sat_detect: need 2 <= SAT_W < ACC_W <= 62");
   end

   localparam logic signed [ACC_W-1:0] HI_LIM = ACC_W'((64'sd1 <<< (SAT_W-1)) - 64'sd1);
   localparam logic signed [ACC_W-1:0] LO_LIM = ACC_W'(-(64'sd1 <<< (SAT_W-1)));

   logic signed [ACC_W-1:0] acc_s;
   assign acc_s   = $signed(acc_i);
   assign over_o  = valid_i && (acc_s > HI_LIM);
   assign under_o = valid_i && (acc_s < LO_LIM);
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/audio_irq_status.sv
module audio_irq_status
   import audio_irq_pkg::*;
#(
   parameter int NCH   = 32,
   parameter int ACC_W = 24,
   parameter int SAT_W = 20,
   parameter int ST_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sb_irq_i,
   input  logic              mpu_irq_i,
   input  logic              tmr_irq_i,
   input  logic [NCH-1:0]    addr_int_a_i,
   input  logic [NCH-1:0]    addr_int_b_i,
   input  logic [NCH-1:0]    env_int_i,
   input  logic              pb_run_i,
   input  logic              pb_fifo_empty_i,
   input  logic              f48_tick_i,
   input  logic              rec_run_i,
   input  logic              rec_req_i,
   input  logic              rec_data_rdy_i,
   input  logic              mix_valid_i,
   input  logic [ACC_W-1:0]  mix_acc_i,
   input  logic [ST_W-1:0]   st_count_i,
   input  logic [ST_W-1:0]   st_target_i,
   input  logic [3:0]        gpio_bits_i,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              pb_half_rate_o
);
   if (ST_W < 1) begin : g_bad
      $error("audio_irq_status: ST_W must be at least 1");
   end

   logic addr_any, env_any, mix_under, mix_over;
   logic half_rate_q, tmr_ie_q, st_ie_q;
   logic [NFLAG-1:0] fset, fclr, fq;

   irq_vec_reduce #(.NCH(NCH), .NVEC(2)) u_addr_or (
      .vec_i ({addr_int_b_i, addr_int_a_i}),
      .any_o (addr_any)
   );

   irq_vec_reduce #(.NCH(NCH), .NVEC(1)) u_env_or (
      .vec_i (env_int_i),
      .any_o (env_any)
   );

   mix_sat_detect #(.ACC_W(ACC_W), .SAT_W(SAT_W)) u_sat (
      .valid_i (mix_valid_i),
      .acc_i   (mix_acc_i),
      .under_o (mix_under),
      .over_o  (mix_over)
   );

   assign fset[FI_UND] = pb_run_i && pb_fifo_empty_i && f48_tick_i;
   assign fset[FI_OVR] = rec_run_i && rec_req_i && !rec_data_rdy_i;
   assign fset[FI_MUF] = mix_under;
   assign fset[FI_MOF] = mix_over;
   assign fset[FI_TGT] = (st_count_i == st_target_i);

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      localparam int BP = flag_bit(i);
      assign fclr[i] = wr_en_i && wr_data_i[BP];
      sticky_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (fset[i]),
         .clr_i (fclr[i]),
         .q_o   (fq[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_rate_q <= 1'b0;
         tmr_ie_q    <= 1'b0;
         st_ie_q     <= 1'b0;
      end else if (wr_en_i) begin
         half_rate_q <= wr_data_i[B_HALF];
         tmr_ie_q    <= wr_data_i[B_TIE];
         st_ie_q     <= wr_data_i[B_SIE];
      end
   end

   always_comb begin
      rd_data_o         = '0;
      rd_data_o[B_SB]   = sb_irq_i;
      rd_data_o[B_MPU]  = mpu_irq_i;
      rd_data_o[B_TMR]  = tmr_irq_i && tmr_ie_q;
      rd_data_o[B_ADDR] = addr_any;
      rd_data_o[B_ENV]  = env_any;
      rd_data_o[B_ST]   = fq[FI_TGT] && st_ie_q;
      rd_data_o[B_UND]  = fq[FI_UND];
      rd_data_o[B_OVR]  = fq[FI_OVR];
      rd_data_o[B_MUF]  = fq[FI_MUF];
      rd_data_o[B_MOF]  = fq[FI_MOF];
      rd_data_o[B_TGT]  = fq[FI_TGT];
      rd_data_o[B_HALF] = half_rate_q;
      rd_data_o[B_TIE]  = tmr_ie_q;
      rd_data_o[B_SIE]  = st_ie_q;
      rd_data_o[B_GPIO] = (gpio_bits_i[0] && gpio_bits_i[2]) ||
                          (gpio_bits_i[1] && gpio_bits_i[3]);
   end

   assign pb_half_rate_o = half_rate_q;

   assert_rsv_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_o & ~DEF_MASK) == '0);
   assert_timer_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data_o[B_TIE] |-> !rd_data_o[B_TMR]);
   assert_mix_over_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mix_valid_i && $signed(mix_acc_i) > $signed(ACC_W'((64'sd1 <<< (SAT_W-1)) - 64'sd1)))
      |=> rd_data_o[B_MOF]);
   assert_st_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_o[B_ST] |-> rd_data_o[B_TGT]);
   assert_mode_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> pb_half_rate_o == $past(wr_data_i[B_HALF]));
   assert_underrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pb_run_i && pb_fifo_empty_i && f48_tick_i) |=> rd_data_o[B_UND]);
endmodule

// File: tb/audio_irq_status_test.sv
module audio_irq_status_test;
   localparam int NCH = 32, ACC_W = 24, SAT_W = 20, ST_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sb, mpu, tmr, pbr, pbe, tick, rr, rq, rdy, mv, wr;
   logic [NCH-1:0] aa, ab, ev;
   logic [ACC_W-1:0] acc;
   logic [ST_W-1:0] cnt, tgt;
   logic [3:0] gp;
   logic [31:0] wd, rd;
   logic half;

   int n_chk = 0, n_fail = 0;
   logic [31:0] m_reg = '0;
   bit done = 0;

   always #10 clk = ~clk;

   audio_irq_status #(.NCH(NCH), .ACC_W(ACC_W), .SAT_W(SAT_W), .ST_W(ST_W)) uut (
      .clk(clk), .rst_n(rst_n), .sb_irq_i(sb), .mpu_irq_i(mpu), .tmr_irq_i(tmr),
      .addr_int_a_i(aa), .addr_int_b_i(ab), .env_int_i(ev),
      .pb_run_i(pbr), .pb_fifo_empty_i(pbe), .f48_tick_i(tick),
      .rec_run_i(rr), .rec_req_i(rq), .rec_data_rdy_i(rdy),
      .mix_valid_i(mv), .mix_acc_i(acc), .st_count_i(cnt), .st_target_i(tgt),
      .gpio_bits_i(gp), .wr_en_i(wr), .wr_data_i(wd),
      .rd_data_o(rd), .pb_half_rate_o(half));

   function automatic logic [31:0] exp_rd();
      logic [31:0] e = m_reg;
      e[2]  = sb;
      e[3]  = mpu;
      e[4]  = tmr & m_reg[17];
      e[5]  = |{aa, ab};
      e[6]  = |ev;
      e[7]  = m_reg[15] & m_reg[23];
      e[24] = (gp[0] & gp[2]) | (gp[1] & gp[3]);
      return e;
   endfunction

   function automatic logic [31:0] next_reg();
      logic [31:0] n = m_reg;
      logic [31:0] setv = '0;
      if (wr) begin
         n[16] = wd[16]; n[17] = wd[17]; n[23] = wd[23];
         n = n & ~(wd & 32'h0000_8F00);
      end
      setv[8]  = pbr & pbe & tick;
      setv[9]  = rr & rq & ~rdy;
      setv[10] = mv && ($signed(acc) < -524288);
      setv[11] = mv && ($signed(acc) > 524287);
      setv[15] = (cnt == tgt);
      return n | setv;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_word();
      logic [31:0] e = exp_rd();
      check("R1",  rd & 32'h0000_000C, e & 32'h0000_000C);
      check("R2",  rd & 32'h0002_0010, e & 32'h0002_0010);
      check("R3",  rd & 32'h0000_0060, e & 32'h0000_0060);
      check("R4",  rd & 32'h0000_0100, e & 32'h0000_0100);
      check("R5",  rd & 32'h0000_0200, e & 32'h0000_0200);
      check("R6",  rd & 32'h0000_0C00, e & 32'h0000_0C00);
      check("R7",  rd & 32'h0080_8080, e & 32'h0080_8080);
      check("R8",  {rd[16], 30'd0, half}, {e[16], 30'd0, e[16]});
      check("R9",  rd & 32'h0100_0000, e & 32'h0100_0000);
      check("R11", rd & 32'hFE7C_7003, 32'h0);
   endtask

   task automatic step();
      #1;
      check_word();
      m_reg = next_reg();
      @(negedge clk);
   endtask

   task automatic quiet();
      {sb, mpu, tmr, pbr, pbe, tick, rr, rq, rdy, mv, wr} = '0;
      aa = '0; ab = '0; ev = '0; acc = '0; gp = '0; wd = '0;
      cnt = 16'd1; tgt = 16'd0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      quiet();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1 check("R11 reset word", rd, 32'h0);
      @(negedge clk);

      // R6 boundaries: exact limits leave flags clear
      mv = 1; acc = 24'(524287); step();
      acc = 24'(-524288); step();
      check("R6 limits", rd & 32'h0C00, 32'h0);
      acc = 24'(524288); step();
      acc = 24'(-524289); step();
      mv = 0;
      check("R6 beyond", rd & 32'h0C00, 32'h0C00);
      // R10 set wins over same-cycle clear
      mv = 1; acc = 24'(600000); wr = 1; wd = 32'h0000_0800; step();
      check("R10 set wins", rd & 32'h0800, 32'h0800);
      mv = 0; wr = 1; wd = 32'h0000_0400; step();
      check("R10 w1c one bit", rd & 32'h0C00, 32'h0800);
      wr = 1; wd = 32'h0; step();
      check("R10 zero keeps", rd & 32'h0800, 32'h0800);
      // R11 reserved writes, R8 mode, R7 enable
      wr = 1; wd = 32'hFFFF_FFFF; step();
      wr = 0; cnt = 16'd5; tgt = 16'd5; step();
      cnt = 16'd1; step();
      check("R11 reserved write", rd & 32'hFE7C_7003, 32'h0);
      check("R8 mode set", {31'd0, half}, 32'd1);
      check("R7 gated irq", rd & 32'h8080, 32'h8080);

      for (int k = 0; k < 400; k++) begin
         sb = 1'($urandom); mpu = 1'($urandom); tmr = 1'($urandom);
         pbr = 1'($urandom); pbe = 1'($urandom); tick = 1'($urandom);
         rr = 1'($urandom); rq = 1'($urandom); rdy = 1'($urandom);
         aa = ($urandom % 4 == 0) ? (32'd1 << ($urandom % 32)) : '0;
         ab = ($urandom % 4 == 0) ? (32'd1 << ($urandom % 32)) : '0;
         ev = ($urandom % 4 == 0) ? (32'd1 << ($urandom % 32)) : '0;
         mv = 1'($urandom);
         case ($urandom % 6)
            0: acc = 24'(524287);  1: acc = 24'(-524288);
            2: acc = 24'(524288);  3: acc = 24'(-524289);
            default: acc = 24'($urandom);
         endcase
         tgt = 16'($urandom % 8); cnt = 16'($urandom % 8);
         gp = 4'($urandom);
         wr = ($urandom % 3 == 0);
         wd = $urandom;
         step();
      end
      quiet(); step();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule